// File: doc/BRIEF.md
# Interleaved Dual-Phase Switching Clock Generator

This block makes the timing base for a two-channel synchronous buck controller. A fast reference clock is divided down to a high-frequency tick that runs at four times the chosen switching rate. A modulo-4 phase counter steps on that tick and produces one switching-rate pulse for each channel. The two pulses are half a switching period apart, so the two channels switch interleaved. A 2-bit select code picks one of three switching rates. Each rate has its own divide ratio, set by a parameter.

Each channel has a transient-enhancement trigger and a per-channel enable for it. When an enabled trigger arrives, that channel stops using its own switching-rate pulse and takes a pulse on every high-frequency tick. This lasts for a window of four ticks, which is about one normal switching period. The channel then hands back to its normal pulse, but only on a tick where its own normal pulse falls, so no shortened period is produced. A flag per channel shows which clock the channel is using.

Top module: `dual_phase_clkgen`

## Requirements
- R1: The ratio is chosen by `freq_sel`. Code 2'b00 (input left floating) selects DIV_FLOAT, the slowest rate. Code 2'b01 (tied high) selects DIV_HIGH, the middle rate. Code 2'b10 (tied low) selects DIV_LOW, the fastest rate. Code 2'b11 also selects DIV_FLOAT. With the selected ratio N, `hf_tick` is high for one reference cycle and then low for N-1 cycles. If a select change leaves the divider at or past N-1, it wraps at once with a tick.
- R2: `hf_clk` is high for the first N/2 (rounded down) reference cycles of each high-frequency period and low for the rest. This gives a 50% duty ratio for even N.
- R3: A phase counter goes 0,1,2,3,0,... and advances after each `hf_tick`. Channel 0's normal pulse falls on the tick at phase 0 and channel 1's on the tick at phase 2. The two channels are therefore interleaved half a switching period apart, and each repeats every 4·N cycles.
- R4: Every `ch_pulse` bit is high for exactly one reference cycle, and only in a cycle where `hf_tick` is high.
- R5: When `tre_trig[i]` and `tre_en[i]` are both high in a cycle, `ch_fast[i]` is high from the next cycle. While `ch_fast[i]` is high, `ch_pulse[i]` follows every `hf_tick`.
- R6: The fast window lasts at least four high-frequency ticks after the last enabled trigger. A trigger inside the window restarts the count at four. A trigger in the same cycle as a tick takes priority, and that tick is not counted.
- R7: Once the window count is used up, the channel leaves fast mode only on a tick that carries its own normal pulse. That tick is still emitted. `ch_fast[i]` falls in the next cycle.
- R8: While `tre_en[i]` is low, `tre_trig[i]` has no effect, and a channel that is not already in fast mode stays in normal mode.
- R9: During and after reset, the divider and the phase counter start at zero and both channels are in normal mode. The first tick comes N-1 cycles after reset is released, at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 2 | Switching-rate select code (R1) |
| tre_en | input | 2 | Per-channel enable of the transient trigger |
| tre_trig | input | 2 | Per-channel transient trigger |
| hf_tick | output | 1 | One-cycle pulse at four times the switching rate |
| hf_clk | output | 1 | High-frequency clock level, 50% duty |
| ch_pulse | output | 2 | Per-channel clock pulse, bit 0 is channel 0 |
| ch_fast | output | 2 | Per-channel flag, high while the channel uses the fast clock |

## Verification
The hardest case to reach from the ports is the exit from fast mode. It is only visible when the window count runs out at a tick that does not carry the channel's own phase, so the channel has to keep running fast until its next boundary tick. To reach it, the stimulus fires triggers at varied offsets from the phase counter, retriggers inside open windows, and fires triggers in cycles that coincide with a tick. It also changes `freq_sel` while windows are open, which moves the divider's wrap point. A behavioural model with its own integer counters predicts every output on every cycle.

// File: rtl/dual_phase_clkgen_pkg.sv
package dual_phase_clkgen_pkg;

    // Frequency select codes, seen from the external strap.
    typedef enum logic [1:0] {
        SEL_FLOAT = 2'b00,
        SEL_HIGH  = 2'b01,
        SEL_LOW   = 2'b10,
        SEL_SPARE = 2'b11
    } freq_sel_e;

    localparam int unsigned PHASES = 4;
    localparam int unsigned PH_W   = $clog2(PHASES);

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/dpc_hf_divider.sv
module dpc_hf_divider
    import dual_phase_clkgen_pkg::*;
#(
    parameter int unsigned DIV_FLOAT = 12,
    parameter int unsigned DIV_HIGH  = 8,
    parameter int unsigned DIV_LOW   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    output logic       tick,
    output logic       hf_level
);
    localparam int unsigned MAX_DIV = max3(DIV_FLOAT, DIV_HIGH, DIV_LOW);
    localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] half_idx;

    always_comb begin
        unique case (freq_sel_e'(freq_sel))
            SEL_HIGH: ratio = CNT_W'(DIV_HIGH);
            SEL_LOW:  ratio = CNT_W'(DIV_LOW);
            default:  ratio = CNT_W'(DIV_FLOAT);
        endcase
        last_idx = ratio - CNT_W'(1);
        half_idx = ratio >> 1;
    end

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.cnt >= last_idx);
        hf_level = (st_q.cnt < half_idx);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: with ratios of two or more a tick is never followed by another
    a_r1_tick_single : assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/dpc_phase_counter.sv
module dpc_phase_counter
    import dual_phase_clkgen_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [NUM_CH-1:0] base_pulse
);
    localparam int unsigned SPACING = PHASES / NUM_CH;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) st_d.ph = st_q.ph + PH_W'(1);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_phase
        localparam logic [PH_W-1:0] OWN_PH = PH_W'(g * SPACING);
        assign base_pulse[g] = tick && (st_q.ph == OWN_PH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the phase only moves on a tick
    a_r3_phase_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.ph));

    // R3: normal pulses of different channels never coincide
    a_r3_phases_apart : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(base_pulse));

endmodule

// File: rtl/dpc_channel_select.sv
module dpc_channel_select #(
    parameter int unsigned WIN_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic own_base,
    input  logic trig,
    input  logic trig_en,
    output logic pulse,
    output logic fast
);
    localparam int unsigned REM_W = $clog2(WIN_TICKS + 1);

    typedef struct packed {
        logic             fast;
        logic [REM_W-1:0] rem;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_en && trig) begin
            st_d.fast = 1'b1;
            st_d.rem  = REM_W'(WIN_TICKS);
        end else if (st_q.fast && tick) begin
            if (st_q.rem > REM_W'(1)) begin
                st_d.rem = st_q.rem - REM_W'(1);
            end else begin
                st_d.rem = '0;
                if (own_base) st_d.fast = 1'b0;
            end
        end
    end

    assign pulse = st_q.fast ? tick : own_base;
    assign fast  = st_q.fast;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r5_trig_enters_fast : assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && trig) |=> st_q.fast);

    a_r8_trig_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !st_q.fast) |=> !st_q.fast);

    a_r6_window_held : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fast && (st_q.rem > REM_W'(1))) |=> st_q.fast);

    a_r7_exit_on_boundary : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.fast) |-> $past(own_base));

endmodule

// File: rtl/dual_phase_clkgen.sv
module dual_phase_clkgen
    import dual_phase_clkgen_pkg::*;
#(
    parameter int unsigned DIV_FLOAT = 12,
    parameter int unsigned DIV_HIGH  = 8,
    parameter int unsigned DIV_LOW   = 6,
    parameter int unsigned WIN_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    input  logic [1:0] tre_en,
    input  logic [1:0] tre_trig,
    output logic       hf_tick,
    output logic       hf_clk,
    output logic [1:0] ch_pulse,
    output logic [1:0] ch_fast
);
    localparam int unsigned NUM_CH = 2;

    logic [NUM_CH-1:0] base_pulse;

    dpc_hf_divider #(
        .DIV_FLOAT(DIV_FLOAT),
        .DIV_HIGH (DIV_HIGH),
        .DIV_LOW  (DIV_LOW)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .freq_sel(freq_sel),
        .tick    (hf_tick),
        .hf_level(hf_clk)
    );

    dpc_phase_counter #(.NUM_CH(NUM_CH)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (hf_tick),
        .base_pulse(base_pulse)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dpc_channel_select #(.WIN_TICKS(WIN_TICKS)) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (hf_tick),
            .own_base(base_pulse[g]),
            .trig    (tre_trig[g]),
            .trig_en (tre_en[g]),
            .pulse   (ch_pulse[g]),
            .fast    (ch_fast[g])
        );

        // R4: a channel pulse only appears with a high-frequency tick
        a_r4_pulse_with_tick : assert property (@(posedge clk) disable iff (!rst_n)
            ch_pulse[g] |-> hf_tick);

        // R4: one reference cycle wide
        a_r4_pulse_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
            ch_pulse[g] |=> !ch_pulse[g]);
    end

endmodule

// File: tb/dual_phase_clkgen_bench.sv
module dual_phase_clkgen_bench;
    localparam int DF = 12, DH = 8, DL = 6, WIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] freq_sel = 2'b00;
    logic [1:0] tre_en = 2'b00;
    logic [1:0] tre_trig = 2'b00;
    logic       hf_tick, hf_clk;
    logic [1:0] ch_pulse, ch_fast;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dual_phase_clkgen #(.DIV_FLOAT(DF), .DIV_HIGH(DH), .DIV_LOW(DL), .WIN_TICKS(WIN))
    u_dual_phase_clkgen (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .tre_en(tre_en),
        .tre_trig(tre_trig), .hf_tick(hf_tick), .hf_clk(hf_clk),
        .ch_pulse(ch_pulse), .ch_fast(ch_fast)
    );

    // Behavioural reference: plain integers tracking time in the divided period.
    int m_cnt = 0;
    int m_ph = 0;
    int m_rem[2] = '{0, 0};
    bit m_fast[2] = '{1'b0, 1'b0};

    function automatic int ratio_for(input logic [1:0] s);
        if (s == 2'b01) return DH;   // R1 tied high
        if (s == 2'b10) return DL;   // R1 tied low
        return DF;                   // R1 floating or spare code
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0;
            for (int i = 0; i < 2; i++) begin m_fast[i] = 0; m_rem[i] = 0; end
        end else begin
            int  r;
            bit  tk;
            r  = ratio_for(freq_sel);
            tk = (m_cnt >= r - 1);
            for (int i = 0; i < 2; i++) begin
                bit own;
                own = tk && (m_ph == 2 * i);
                if (tre_en[i] && tre_trig[i]) begin
                    m_fast[i] = 1; m_rem[i] = WIN;
                end else if (m_fast[i] && tk) begin
                    if (m_rem[i] > 1) m_rem[i]--;
                    else begin m_rem[i] = 0; if (own) m_fast[i] = 0; end
                end
            end
            if (tk) begin m_cnt = 0; m_ph = (m_ph + 1) % 4; end
            else m_cnt++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare every cycle, late in the low phase of the clock.
    always @(negedge clk) begin
        #8;
        begin
            int r;
            bit tk;
            r  = ratio_for(freq_sel);
            tk = (m_cnt >= r - 1);
            chk("R1", "hf_tick", hf_tick, tk);
            chk("R2", "hf_clk", hf_clk, m_cnt < r / 2);
            for (int i = 0; i < 2; i++) begin
                bit own;
                own = tk && (m_ph == 2 * i);
                // R3 phase placement, R4 width, R5 fast pulses, R7 boundary exit
                chk("R3/R4/R5/R7", $sformatf("ch_pulse[%0d]", i), ch_pulse[i],
                    m_fast[i] ? tk : own);
                // R5 entry, R6 window, R8 ignore
                chk("R5/R6/R8", $sformatf("ch_fast[%0d]", i), ch_fast[i], m_fast[i]);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input int ch);
        @(negedge clk);
        tre_trig[ch] = 1'b1;
        @(negedge clk);
        tre_trig[ch] = 1'b0;
    endtask

    task automatic fire_on_tick(input int ch);
        while (!(u_dual_phase_clkgen.hf_tick === 1'b0)) @(negedge clk);
        @(posedge hf_tick);
        @(negedge clk);
        while (hf_tick !== 1'b1) @(negedge clk);
        tre_trig[ch] = 1'b1;
        @(negedge clk);
        tre_trig[ch] = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        // R9: reset state seen at the ports
        chk("R9", "ch_fast in reset", ch_fast, 0);
        chk("R9", "ch_pulse in reset", ch_pulse, 0);
        rst_n = 1'b1;
        wait_cyc(DF * 10);                       // R3 interleave, slow rate
        tre_en = 2'b01;
        fire(1);                                 // R8: channel 1 disabled
        wait_cyc(5);
        chk("R8", "ch_fast[1] after disabled trigger", ch_fast[1], 0);
        fire(0);                                 // R5 entry
        wait_cyc(DF * 2 + 3);
        fire(0);                                 // R6 retrigger inside the window
        wait_cyc(DF * 12);                       // R7 boundary exit
        tre_en = 2'b11;
        for (int k = 0; k < 6; k++) begin
            fire(k % 2);
            wait_cyc(DF * k + 5);
        end
        fire_on_tick(1);                         // R6 trigger coinciding with a tick
        wait_cyc(DF * 10);
        freq_sel = 2'b01;                        // R1 middle rate
        wait_cyc(DH * 10);
        fire(0); fire(1);
        wait_cyc(DH * 3);
        freq_sel = 2'b10;                        // R1 fast rate, change inside a window
        wait_cyc(DL * 16);
        tre_trig = 2'b11;                        // both channels at once
        @(negedge clk); tre_trig = 2'b00;
        wait_cyc(DL * 12);
        freq_sel = 2'b11;                        // R1 spare code
        for (int k = 0; k < 10; k++) begin
            fire_on_tick(k % 2);
            wait_cyc(k * 7 + 1);
        end
        wait_cyc(DF * 12);
        tre_en = 2'b00;
        fire(0);                                 // R8 after the window has closed
        wait_cyc(3);
        chk("R8", "ch_fast[0] after disabled trigger", ch_fast[0], 0);
        rst_n = 1'b0;                            // R9 reset mid-run
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(DF * 6);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule